// File: doc/BRIEF.md
# Line-Control-Driven UART Transmitter

This block serialises bytes written by a host into asynchronous serial frames. A byte written into a one-entry holding register moves into a shift register. It moves at once when the transmitter is idle, or at the end of the current frame's stop period when a frame is in progress. The frame is then sent as one low start bit, the data bits LSB first, an optional parity bit and the stop period. Every bit lasts a fixed number of pulses of an external oversampling baud enable.

A seven-bit line control input sets the frame format: word length, stop length, parity enable, even/odd select, stick parity and break. The word length, stop length and parity settings are sampled when a byte enters the shift register, so a frame keeps its format even if the control changes while it is sent. The break bit acts at once on the line. Two status outputs report when the holding register is free and when the transmitter has fully drained. A loopback input holds the serial pin high and sends the frame out on a separate internal line instead.

The sequencer has five states. IDLE goes to START when the holding register is full (load). START goes to DATA when its bit period ends. DATA repeats until the last data bit ends, then goes to PARITY if parity is enabled and to STOP otherwise. PARITY goes to STOP. STOP goes to START when the holding register is full at the end of the stop period (back-to-back load), and to IDLE otherwise.

Top module: `uart_lc_tx`

## Requirements
- R1: After reset `txd` and `loop_rxd` are high, and `hold_empty` and `tx_empty` are both 1. With no break and no loopback, the line stays high while the transmitter is empty.
- R2: `line_ctl[1:0]` = 00, 01, 10, 11 selects 5, 6, 7 or 8 data bits. The frame is one low start bit followed by the data bits LSB first, and each bit lasts OVERSAMPLE enabled `baud_tick` cycles.
- R3: When `line_ctl[2]` is 0 the stop period is one bit (OVERSAMPLE ticks). When it is 1, the stop period is 1.5 bits (OVERSAMPLE*3/2 ticks) for 5-bit words and 2 bits otherwise. The stop level is high.
- R4: When `line_ctl[3]` is 1, a parity bit follows the last data bit and comes before the stop period. `line_ctl[4]`=1 gives even parity (data ones plus parity is even) and 0 gives odd parity.
- R5: When `line_ctl[5]` (stick) and `line_ctl[3]` are both 1, the parity bit is 0 if `line_ctl[4]` is 1 and 1 if `line_ctl[4]` is 0.
- R6: While `line_ctl[6]` is 1, the line is forced low. The frame keeps advancing underneath, and the line returns to the frame level (high when idle) once the bit clears.
- R7: A byte written while the transmitter is idle has its start bit on the line after the second clock edge following the write. A byte held during a frame starts right after that frame's stop period, with no idle bit in between.
- R8: `hold_empty` goes low on the clock edge after a write and returns high on the edge that moves the byte into the shift register. `tx_empty` is 1 only when the holding register is empty and no frame is in progress.
- R9: When `loop_en` is 1, `txd` is held high and `loop_rxd` carries the line level, including break. When `loop_en` is 0, `loop_rxd` is high.
- R10: A write while the holding register is full replaces the held byte, so the last written byte is the one sent. Word length, stop and parity settings are taken at the moment of the move into the shift register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | Oversampling baud enable, one pulse per sub-bit period |
| wr_en | input | 1 | Host write strobe for the holding register |
| wr_data | input | 8 | Byte to transmit |
| line_ctl | input | 7 | Frame format and break control |
| loop_en | input | 1 | Loopback select |
| txd | output | 1 | Serial output pin |
| loop_rxd | output | 1 | Internal loopback line toward a receiver |
| hold_empty | output | 1 | Holding register can accept a byte |
| tx_empty | output | 1 | Holding and shift registers both empty |

## Verification
The bench builds the block with OVERSAMPLE=4 rather than the default 16. Frames therefore stay short enough to cover all four word lengths, every stop and parity combination, stick parity, overwrite, back-to-back frames, break and loopback in one short run. With 4 the 1.5-bit stop lasts 6 ticks, so the half-bit path is still exercised with an integer count. The baud enable is withheld on every third cycle, so a wrong count of ticks against clocks shows up as a misplaced edge.

// File: rtl/uart_lc_tx_pkg.sv
package uart_lc_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_t;

    localparam int LC_STOP  = 2;
    localparam int LC_PEN   = 3;
    localparam int LC_EVEN  = 4;
    localparam int LC_STICK = 5;
    localparam int LC_BREAK = 6;

    function automatic logic calc_parity(input logic [7:0] d, input logic [1:0] wl,
                                         input logic even_sel, input logic stick);
        logic [7:0] mask;
        mask = 8'hFF >> (2'd3 - wl);
        if (stick)
            return ~even_sel;
        return even_sel ? ^(d & mask) : ~^(d & mask);
    endfunction

endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          take,
    output logic [DW-1:0] hold_data,
    output logic          hold_full
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_data <= '0;
            hold_full <= 1'b0;
        end else begin
            if (wr_en) begin
                hold_data <= wr_data;
                hold_full <= 1'b1;
            end else if (take) begin
                hold_full <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/uart_tx_seq.sv
module uart_tx_seq
    import uart_lc_tx_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [5:0] fmt,
    input  logic       hold_full,
    input  logic [7:0] hold_data,
    output logic       take,
    output logic       frame_bit,
    output logic       busy
);
    localparam int CW = $clog2(2 * OVERSAMPLE);
    localparam logic [CW-1:0] BIT_LAST  = CW'(OVERSAMPLE - 1);
    localparam logic [CW-1:0] HALF_LAST = CW'(OVERSAMPLE * 3 / 2 - 1);
    localparam logic [CW-1:0] TWO_LAST  = CW'(2 * OVERSAMPLE - 1);

    tx_state_t     state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic [7:0]    shreg_q;
    logic [2:0]    left_q;
    logic          par_q, pen_q, long_stop_q, short_word_q;
    logic          load, adv, bit_end, stop_end;
    logic [CW-1:0] stop_last;

    always_comb begin
        if (!long_stop_q)
            stop_last = BIT_LAST;
        else if (short_word_q)
            stop_last = HALF_LAST;
        else
            stop_last = TWO_LAST;
    end

    assign bit_end  = tick && (cnt_q == BIT_LAST);
    assign stop_end = tick && (cnt_q == stop_last);

    // next state
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        adv     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (hold_full) begin
                    load    = 1'b1;
                    state_d = ST_START;
                end
            end
            ST_START: begin
                if (bit_end) begin
                    adv     = 1'b1;
                    state_d = ST_DATA;
                end
            end
            ST_DATA: begin
                if (bit_end) begin
                    adv = 1'b1;
                    if (left_q == 3'd0)
                        state_d = pen_q ? ST_PARITY : ST_STOP;
                end
            end
            ST_PARITY: begin
                if (bit_end) begin
                    adv     = 1'b1;
                    state_d = ST_STOP;
                end
            end
            ST_STOP: begin
                if (stop_end) begin
                    adv = 1'b1;
                    if (hold_full) begin
                        load    = 1'b1;
                        state_d = ST_START;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            cnt_q        <= '0;
            shreg_q      <= '0;
            left_q       <= '0;
            par_q        <= 1'b0;
            pen_q        <= 1'b0;
            long_stop_q  <= 1'b0;
            short_word_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (load || adv)
                cnt_q <= '0;
            else if (tick && state_q != ST_IDLE)
                cnt_q <= cnt_q + 1'b1;
            if (load) begin
                shreg_q      <= hold_data;
                left_q       <= 3'd4 + {1'b0, fmt[1:0]};
                par_q        <= calc_parity(hold_data, fmt[1:0], fmt[LC_EVEN], fmt[LC_STICK]);
                pen_q        <= fmt[LC_PEN];
                long_stop_q  <= fmt[LC_STOP];
                short_word_q <= (fmt[1:0] == 2'b00);
            end else if (adv && state_q == ST_DATA) begin
                shreg_q <= shreg_q >> 1;
                left_q  <= left_q - 3'd1;
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_START:  frame_bit = 1'b0;
            ST_DATA:   frame_bit = shreg_q[0];
            ST_PARITY: frame_bit = par_q;
            default:   frame_bit = 1'b1;
        endcase
    end

    assign take = load;
    assign busy = (state_q != ST_IDLE);
endmodule

// File: rtl/uart_lc_tx.sv
module uart_lc_tx
    import uart_lc_tx_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       baud_tick,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic [6:0] line_ctl,
    input  logic       loop_en,
    output logic       txd,
    output logic       loop_rxd,
    output logic       hold_empty,
    output logic       tx_empty
);
    logic [7:0] hold_data;
    logic       hold_full, take, frame_bit, seq_busy, line_bit;

    uart_tx_hold #(.DW(8)) hold_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .take      (take),
        .hold_data (hold_data),
        .hold_full (hold_full)
    );

    uart_tx_seq #(.OVERSAMPLE(OVERSAMPLE)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (baud_tick),
        .fmt       (line_ctl[5:0]),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .take      (take),
        .frame_bit (frame_bit),
        .busy      (seq_busy)
    );

    assign line_bit   = line_ctl[LC_BREAK] ? 1'b0 : frame_bit;
    assign txd        = loop_en ? 1'b1 : line_bit;
    assign loop_rxd   = loop_en ? line_bit : 1'b1;
    assign hold_empty = ~hold_full;
    assign tx_empty   = ~hold_full & ~seq_busy;
endmodule

// File: rtl/uart_lc_tx_chk.sv
module uart_lc_tx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       wr_en,
    input logic [6:0] line_ctl,
    input logic       loop_en,
    input logic       txd,
    input logic       hold_empty,
    input logic       tx_empty,
    input logic       frame_bit,
    input logic       seq_busy
);
    // R8
    write_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !hold_empty);

    // R8
    empty_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> hold_empty);

    // R2
    bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_busy && !tick) |=> $stable(frame_bit));

    // R7
    idle_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_busy && !hold_empty && !wr_en) |=> seq_busy);

    // R6
    break_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_ctl[6] && !loop_en) |-> !txd);

    // R9
    loop_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loop_en |-> txd);

    // R1
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_empty && !line_ctl[6] && !loop_en) |-> txd);
endmodule

bind uart_lc_tx uart_lc_tx_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (baud_tick),
    .wr_en      (wr_en),
    .line_ctl   (line_ctl),
    .loop_en    (loop_en),
    .txd        (txd),
    .hold_empty (hold_empty),
    .tx_empty   (tx_empty),
    .frame_bit  (frame_bit),
    .seq_busy   (seq_busy)
);

// File: tb/uart_lc_tx_test.sv
module uart_lc_tx_test;
    localparam int OSR = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [6:0] line_ctl = '0;
    logic       loop_en = 1'b0;
    logic       txd, loop_rxd, hold_empty, tx_empty;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;
    string cur_tag = "R2";

    // reference model state
    int   lvl_q[$];
    int   len_q[$];
    bit   m_full = 0;
    logic [7:0] m_hold = '0;

    always #2 clk = ~clk;

    uart_lc_tx #(.OVERSAMPLE(OSR)) uut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en),
        .wr_data(wr_data), .line_ctl(line_ctl), .loop_en(loop_en),
        .txd(txd), .loop_rxd(loop_rxd), .hold_empty(hold_empty), .tx_empty(tx_empty)
    );

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    function automatic void build_frame(input logic [7:0] d, input logic [6:0] lc);
        int nb;
        int ones;
        logic par;
        nb = 5 + int'(lc[1:0]);
        ones = 0;
        lvl_q.push_back(0); len_q.push_back(OSR);
        for (int i = 0; i < nb; i++) begin
            lvl_q.push_back(int'(d[i])); len_q.push_back(OSR);
            ones += int'(d[i]);
        end
        if (lc[3]) begin
            if (lc[5]) par = ~lc[4];
            else if (lc[4]) par = ones[0];
            else par = ~ones[0];
            lvl_q.push_back(int'(par)); len_q.push_back(OSR);
        end
        lvl_q.push_back(1);
        if (!lc[2]) len_q.push_back(OSR);
        else if (nb == 5) len_q.push_back(OSR * 3 / 2);
        else len_q.push_back(2 * OSR);
    endfunction

    // reference model, advanced at every clock edge
    always @(posedge clk) begin
        if (!rst_n) begin
            lvl_q.delete(); len_q.delete(); m_full = 0;
        end else begin
            bit old_full;
            bit took;
            old_full = m_full;
            took = 0;
            if (lvl_q.size() > 0) begin
                if (baud_tick) begin
                    len_q[0]--;
                    if (len_q[0] == 0) begin
                        void'(lvl_q.pop_front()); void'(len_q.pop_front());
                        if (lvl_q.size() == 0 && old_full) begin
                            build_frame(m_hold, line_ctl); took = 1;
                        end
                    end
                end
            end else if (old_full) begin
                build_frame(m_hold, line_ctl); took = 1;
            end
            if (took) m_full = 0;
            if (wr_en) begin m_hold = wr_data; m_full = 1; end
        end
    end

    // stimulus timing: inputs change 1 ns after the rising edge
    always @(posedge clk) begin
        #1;
        cyc++;
        baud_tick = (cyc % 3) != 2;
    end

    // compare on every falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic lvl;
            lvl = (lvl_q.size() == 0) ? 1'b1 : lvl_q[0][0];
            if (line_ctl[6]) lvl = 1'b0;
            check(loop_en ? "R9" : (line_ctl[6] ? "R6" : cur_tag), "txd", txd, loop_en ? 1'b1 : lvl);
            check("R9", "loop_rxd", loop_rxd, loop_en ? lvl : 1'b1);
            check("R8", "hold_empty", hold_empty, !m_full);
            check("R8", "tx_empty", tx_empty, !m_full && lvl_q.size() == 0);
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic write_byte(input logic [7:0] d);
        while (!hold_empty) step(1);
        wr_data = d; wr_en = 1'b1;
        step(1);
        wr_en = 1'b0;
    endtask

    task automatic drain();
        step(1);
        while (!tx_empty) step(1);
        step(2);
    endtask

    task automatic send(input string tag, input logic [6:0] lc, input logic [7:0] d);
        cur_tag = tag;
        line_ctl = lc;
        write_byte(d);
        drain();
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1", "reset txd", txd, 1'b1);
        check("R1", "reset loop_rxd", loop_rxd, 1'b1);
        check("R1", "reset hold_empty", hold_empty, 1'b1);
        check("R1", "reset tx_empty", tx_empty, 1'b1);
        step(4);

        // R2 word lengths, one stop bit, no parity
        for (int w = 0; w < 4; w++) send("R2", 7'(w), 8'hA5 ^ 8'(w * 37));
        send("R2", 7'b0000011, 8'h01);

        // R3 stop lengths
        send("R3", 7'b0000100, 8'h13);
        send("R3", 7'b0000101, 8'h2C);
        send("R3", 7'b0000111, 8'hF0);

        // R4 parity even and odd
        send("R4", 7'b0011011, 8'h07);
        send("R4", 7'b0001011, 8'h07);
        send("R4", 7'b0011000, 8'hE1);
        send("R4", 7'b0001110, 8'h5A);

        // R5 stick parity
        send("R5", 7'b0111011, 8'hFF);
        send("R5", 7'b0101011, 8'h00);

        // R7 back-to-back frames
        cur_tag = "R7";
        line_ctl = 7'b0001111;
        write_byte(8'h3C);
        write_byte(8'hC3);
        write_byte(8'h99);
        drain();

        // R10 overwrite of held byte, format taken at transfer
        cur_tag = "R10";
        line_ctl = 7'b0000011;
        write_byte(8'h11);
        step(2);
        wr_data = 8'h22; wr_en = 1'b1; step(1);
        wr_data = 8'h33; step(1);
        wr_en = 1'b0;
        line_ctl = 7'b0011001;
        drain();

        // R6 break in the middle of a frame and while idle
        cur_tag = "R6";
        line_ctl = 7'b0000011;
        write_byte(8'h55);
        step(10);
        line_ctl = 7'b1000011;
        step(9);
        line_ctl = 7'b0000011;
        drain();
        line_ctl = 7'b1000011;
        step(5);
        line_ctl = 7'b0000011;
        step(3);

        // R9 loopback
        loop_en = 1'b1;
        send("R9", 7'b0011011, 8'hB2);
        line_ctl = 7'b1000000;
        step(4);
        line_ctl = 7'b0000000;
        loop_en = 1'b0;
        step(4);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule